// File: doc/BRIEF.md
# Tuning-Word Serial Register Receiver

This block is a write-only I2C slave for a frequency synthesizer controller. It takes SCL and SDA from the bus and brings them into the system clock domain. It finds START and STOP conditions and shifts in bytes. It acknowledges the bytes it accepts. Each transfer begins with a device address byte and is followed by data bytes that come in pairs. The top bit of the first byte of each pair selects the pair's meaning. A 0 marks a frequency pair, sent high byte then low byte. A 1 marks a control pair, sent control byte then band byte.

A finished pair sits in a holding register until its second byte has been acknowledged. It is then copied in one system clock to the registered outputs, and a single-cycle strobe shows which word changed. The rest of the chip reads a 15-bit divider word, a control byte and a band byte. The block acknowledges at most four data bytes per transfer. An unpaired third byte is dropped, and a pair that is cut short by a STOP or a repeated START is lost without effect.

Top module: `tune_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `freq_word`, `ctrl_byte` and `band_byte` are zero, `sda_oe` is low, and both update strobes are low.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` and whose bit 0 (R/W) is 0 is acknowledged. Any other address byte, including a read, is not acknowledged. No data byte after it is acknowledged or stored until the next START.
- R3: For an acknowledged byte, `sda_oe` goes high only while SCL is low after the eighth rising edge of SCL. It stays high through the ninth SCL high phase and drops while SCL is low after that phase. During the eight data bits it is always low.
- R4: A pair whose first byte has bit 7 = 0 sets `freq_word` to {first byte bits 6..0, second byte}. This happens only in the cycle where `upd_freq` pulses.
- R5: A pair whose first byte has bit 7 = 1 sets `ctrl_byte` to the first byte and `band_byte` to the second byte. This happens only in the cycle where `upd_ctrl` pulses.
- R6: In a transfer with four data bytes, the pairs may come in either order, and each pair updates its own word.
- R7: When exactly three data bytes arrive, the first pair is applied and the third byte changes no output.
- R8: The first four data bytes after a valid address are acknowledged. A fifth or later byte is not acknowledged and changes no output.
- R9: A STOP or a repeated START received after only the first byte of a pair drops that byte. No output changes from it, and the next byte after a new address is again the first of a pair.
- R10: `upd_freq` and `upd_ctrl` are single-cycle pulses that never occur together. Exactly one pulse comes for each completed pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus (asynchronous) |
| sda_i | input | 1 | Serial data from the bus (asynchronous) |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| freq_word | output | 15 | Divider word |
| ctrl_byte | output | 8 | Control byte |
| band_byte | output | 8 | Band byte |
| upd_freq | output | 1 | One-cycle pulse when `freq_word` is loaded |
| upd_ctrl | output | 1 | One-cycle pulse when `ctrl_byte` and `band_byte` are loaded |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h63, which is not the default. This shows that both the address match and the read/write reject follow the parameter and are not fixed in the logic. `SYNC_STAGES` is set to 3. The deeper pipeline moves every START, STOP and edge detection one cycle later, which tests that the acknowledge still starts and ends while SCL is low. With these values, the bench can cover address match and mismatch, both pair orders, the three- and five-byte cases, and pairs cut off by STOP or by a repeated START.

// File: rtl/tune_rx_pkg.sv
package tune_rx_pkg;
  localparam int BYTE_W   = 8;
  localparam int FREQ_W   = 2 * BYTE_W - 1;
  localparam int MAX_DATA = 4;
  localparam int DCNT_W   = $clog2(MAX_DATA + 1);
  localparam int BITC_W   = $clog2(BYTE_W + 2);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    PAIR_FREQ = 1'b0,
    PAIR_CTRL = 1'b1
  } pair_kind_e;
endpackage

// File: rtl/tune_rx_sync.sv
module tune_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;
  logic              scl_s;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[STAGES-1];
      sda_d <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/tune_rx_bitio.sv
module tune_rx_bitio
  import tune_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  active,
  input  logic  start_det,
  input  logic  stop_det,
  input  logic  scl_rise,
  input  logic  scl_fall,
  input  logic  sda_s,
  input  logic  ack_want,
  output logic  byte_done,
  output byte_t rx_byte,
  output logic  ack_end,
  output logic  sda_oe
);
  localparam logic [BITC_W-1:0] LAST_BIT = BITC_W'(BYTE_W - 1);
  localparam logic [BITC_W-1:0] ACK_SLOT = BITC_W'(BYTE_W);
  localparam logic [BITC_W-1:0] ACK_HIGH = BITC_W'(BYTE_W + 1);

  logic [BITC_W-1:0] bit_cnt;
  byte_t             shreg;

  always_ff @(posedge clk) begin
    if (rst || start_det || stop_det) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      ack_end   <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      ack_end   <= 1'b0;
      if (active) begin
        if (scl_rise) begin
          if (bit_cnt < ACK_SLOT) shreg <= {shreg[BYTE_W-2:0], sda_s};
          if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
          if (bit_cnt < ACK_HIGH) bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall) begin
          if (bit_cnt == ACK_SLOT) begin
            sda_oe <= ack_want;
          end else if (bit_cnt == ACK_HIGH) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            ack_end <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_byte = shreg;
endmodule

// File: rtl/tune_rx_sorter.sv
module tune_rx_sorter
  import tune_rx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  byte_t             rx_byte,
  input  logic              ack_end,
  output logic              active,
  output logic              ack_want,
  output logic [FREQ_W-1:0] freq_word,
  output byte_t             ctrl_byte,
  output byte_t             band_byte,
  output logic              upd_freq,
  output logic              upd_ctrl
);
  localparam logic [DCNT_W-1:0] DCNT_MAX = DCNT_W'(MAX_DATA);

  logic              addr_phase;
  logic              addr_ok;
  logic [DCNT_W-1:0] dcnt;
  byte_t             hold_byte;
  byte_t             pend_lo;
  logic              pend;
  logic              addr_match;
  pair_kind_e        hold_kind;

  assign addr_match = (rx_byte[BYTE_W-1:1] == DEV_ADDR) && !rx_byte[0];
  assign hold_kind  = pair_kind_e'(hold_byte[BYTE_W-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      addr_phase <= 1'b0;
      addr_ok    <= 1'b0;
      dcnt       <= '0;
      hold_byte  <= '0;
      pend_lo    <= '0;
      pend       <= 1'b0;
      ack_want   <= 1'b0;
      freq_word  <= '0;
      ctrl_byte  <= '0;
      band_byte  <= '0;
      upd_freq   <= 1'b0;
      upd_ctrl   <= 1'b0;
    end else begin
      upd_freq <= 1'b0;
      upd_ctrl <= 1'b0;
      if (start_det) begin
        active     <= 1'b1;
        addr_phase <= 1'b1;
        addr_ok    <= 1'b0;
        dcnt       <= '0;
        pend       <= 1'b0;
        ack_want   <= 1'b0;
      end else if (stop_det) begin
        active     <= 1'b0;
        addr_phase <= 1'b0;
        addr_ok    <= 1'b0;
        dcnt       <= '0;
        pend       <= 1'b0;
        ack_want   <= 1'b0;
      end else begin
        if (byte_done) begin
          if (addr_phase) begin
            addr_phase <= 1'b0;
            addr_ok    <= addr_match;
            ack_want   <= addr_match;
          end else if (addr_ok && dcnt < DCNT_MAX) begin
            ack_want <= 1'b1;
            dcnt     <= dcnt + 1'b1;
            if (!dcnt[0]) begin
              hold_byte <= rx_byte;
            end else begin
              pend_lo <= rx_byte;
              pend    <= 1'b1;
            end
          end else begin
            ack_want <= 1'b0;
          end
        end
        if (ack_end && pend) begin
          pend <= 1'b0;
          if (hold_kind == PAIR_FREQ) begin
            freq_word <= {hold_byte[BYTE_W-2:0], pend_lo};
            upd_freq  <= 1'b1;
          end else begin
            ctrl_byte <= hold_byte;
            band_byte <= pend_lo;
            upd_ctrl  <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tune_rx.sv
module tune_rx
  import tune_rx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h61,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [FREQ_W-1:0] freq_word,
  output logic [BYTE_W-1:0] ctrl_byte,
  output logic [BYTE_W-1:0] band_byte,
  output logic              upd_freq,
  output logic              upd_ctrl
);
  logic  sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic  active, ack_want, byte_done, ack_end;
  byte_t rx_byte;

  tune_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  tune_rx_bitio u_bitio (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .start_det(start_det),
    .stop_det (stop_det),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .ack_want (ack_want),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .ack_end  (ack_end),
    .sda_oe   (sda_oe)
  );

  tune_rx_sorter #(.DEV_ADDR(DEV_ADDR)) u_sorter (
    .clk      (clk),
    .rst      (rst),
    .start_det(start_det),
    .stop_det (stop_det),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .ack_end  (ack_end),
    .active   (active),
    .ack_want (ack_want),
    .freq_word(freq_word),
    .ctrl_byte(ctrl_byte),
    .band_byte(band_byte),
    .upd_freq (upd_freq),
    .upd_ctrl (upd_ctrl)
  );
endmodule

// File: rtl/tune_rx_chk.sv
module tune_rx_chk
  import tune_rx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_i,
  input logic              sda_oe,
  input logic [FREQ_W-1:0] freq_word,
  input logic [BYTE_W-1:0] ctrl_byte,
  input logic [BYTE_W-1:0] band_byte,
  input logic              upd_freq,
  input logic              upd_ctrl
);
  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (freq_word == '0 && ctrl_byte == '0 && band_byte == '0 && !sda_oe && !upd_freq && !upd_ctrl)); // R1
  AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_i); // R3
  AST_ACK_ENDS_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $fell(sda_oe) |-> !scl_i); // R3
  AST_FREQ_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst) !upd_freq |-> $stable(freq_word)); // R4
  AST_CTRL_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst) !upd_ctrl |-> $stable({ctrl_byte, band_byte})); // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({upd_freq, upd_ctrl})); // R10
  AST_FREQ_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst) upd_freq |=> !upd_freq); // R10
  AST_CTRL_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst) upd_ctrl |=> !upd_ctrl); // R10
endmodule

bind tune_rx tune_rx_chk u_chk (.*);

// File: tb/sim_tune_rx.sv
module sim_tune_rx;
  localparam logic [6:0] ADDR = 7'h63;
  localparam int SYNC = 3;
  localparam int Q    = 10;
  localparam int NROW = 7;

  typedef struct packed {
    logic [2:0]  nd;
    logic [39:0] d;
    logic [14:0] f;
    logic [7:0]  c;
    logic [7:0]  b;
  } row_t;

  // Expected outputs carry over from row to row.
  localparam row_t VEC [NROW] = '{
    '{nd: 3'd2, d: {8'h12, 8'h34, 24'h0},                 f: 15'h1234, c: 8'h00, b: 8'h00}, // R4
    '{nd: 3'd2, d: {8'h8E, 8'h05, 24'h0},                 f: 15'h1234, c: 8'h8E, b: 8'h05}, // R5
    '{nd: 3'd4, d: {8'hC1, 8'h22, 8'h7F, 8'hFF, 8'h00},   f: 15'h7FFF, c: 8'hC1, b: 8'h22}, // R6 control first
    '{nd: 3'd4, d: {8'h05, 8'hA0, 8'h90, 8'h44, 8'h00},   f: 15'h05A0, c: 8'h90, b: 8'h44}, // R6 frequency first
    '{nd: 3'd3, d: {8'h33, 8'h44, 8'h81, 16'h0},          f: 15'h3344, c: 8'h90, b: 8'h44}, // R7
    '{nd: 3'd5, d: {8'h82, 8'h11, 8'h01, 8'h02, 8'hFF},   f: 15'h0102, c: 8'h82, b: 8'h11}, // R8
    '{nd: 3'd5, d: {8'h00, 8'h00, 8'h8A, 8'h0B, 8'h12},   f: 15'h0000, c: 8'h8A, b: 8'h0B}  // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_bus;
  logic        sda_oe;
  logic [14:0] freq_word;
  logic [7:0]  ctrl_byte, band_byte;
  logic        upd_freq, upd_ctrl;

  int errs = 0;
  int checks = 0;
  int nf = 0;
  int nc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  tune_rx #(.DEV_ADDR(ADDR), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .freq_word(freq_word), .ctrl_byte(ctrl_byte), .band_byte(band_byte),
    .upd_freq(upd_freq), .upd_ctrl(upd_ctrl)
  );

  always @(negedge clk) begin
    if (upd_freq) nf++;
    if (upd_ctrl) nc++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output bit clean);
    clean = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(Q);
      scl_m = 1'b1; wait_clk(Q);
      if (sda_oe) clean = 1'b0;
      wait_clk(Q);
      scl_m = 1'b0; wait_clk(Q);
    end
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    acked = !sda_bus;
    wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic check_outputs(input string tag, input int f, input int c, input int b);
    chk({tag, " freq_word"}, int'(freq_word), f);
    chk({tag, " ctrl_byte"}, int'(ctrl_byte), c);
    chk({tag, " band_byte"}, int'(band_byte), b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit a, cl;
    int f0, c0, ef, ec;

    wait_clk(5);
    check_outputs("R1 in reset", 0, 0, 0);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    rst = 1'b0;
    wait_clk(5);

    // Table walk: R4..R8, R10, R3
    for (int r = 0; r < NROW; r++) begin
      f0 = nf; c0 = nc; ef = 0; ec = 0;
      i2c_start();
      send_byte({ADDR, 1'b0}, a, cl);
      chk("R2 address ack", int'(a), 1);
      for (int i = 0; i < int'(VEC[r].nd); i++) begin
        send_byte(VEC[r].d[39 - 8 * i -: 8], a, cl);
        chk("R8 data ack", int'(a), (i < 4) ? 1 : 0);
        chk("R3 sda_oe low in data bits", int'(cl), 1);
      end
      for (int p = 0; p < 4; p += 2) begin
        if (p + 1 < int'(VEC[r].nd)) begin
          if (VEC[r].d[39 - 8 * p]) ec++; else ef++;
        end
      end
      i2c_stop();
      wait_clk(4);
      check_outputs("R4/R5 row", int'(VEC[r].f), int'(VEC[r].c), int'(VEC[r].b));
      chk("R10 freq strobes", nf - f0, ef);
      chk("R10 ctrl strobes", nc - c0, ec);
    end

    // R2: wrong address
    i2c_start();
    send_byte({ADDR + 7'd1, 1'b0}, a, cl);
    chk("R2 wrong address not acked", int'(a), 0);
    send_byte(8'h15, a, cl);
    chk("R2 data after wrong address", int'(a), 0);
    send_byte(8'h16, a, cl);
    chk("R2 data after wrong address", int'(a), 0);
    i2c_stop();
    wait_clk(4);
    check_outputs("R2 wrong address", 16'h0000, 8'h8A, 8'h0B);

    // R2: read request
    i2c_start();
    send_byte({ADDR, 1'b1}, a, cl);
    chk("R2 read not acked", int'(a), 0);
    send_byte(8'h8F, a, cl);
    chk("R2 data after read", int'(a), 0);
    i2c_stop();
    wait_clk(4);
    check_outputs("R2 read", 16'h0000, 8'h8A, 8'h0B);

    // R9: repeated START after the first byte of a pair
    f0 = nf; c0 = nc;
    i2c_start();
    send_byte({ADDR, 1'b0}, a, cl);
    send_byte(8'h11, a, cl);
    chk("R9 first byte acked", int'(a), 1);
    i2c_start();
    send_byte({ADDR, 1'b0}, a, cl);
    chk("R9 address after restart", int'(a), 1);
    send_byte(8'h8C, a, cl);
    send_byte(8'h0D, a, cl);
    i2c_stop();
    wait_clk(4);
    check_outputs("R9 restart", 16'h0000, 8'h8C, 8'h0D);
    chk("R9 freq strobes", nf - f0, 0);
    chk("R9 ctrl strobes", nc - c0, 1);

    // R9: STOP after the first byte of a pair
    f0 = nf;
    i2c_start();
    send_byte({ADDR, 1'b0}, a, cl);
    send_byte(8'h22, a, cl);
    i2c_stop();
    wait_clk(4);
    check_outputs("R9 stop", 16'h0000, 8'h8C, 8'h0D);
    chk("R9 no freq strobe", nf - f0, 0);

    // R1: reset after activity
    wait_clk(2);
    rst = 1'b1;
    wait_clk(3);
    check_outputs("R1 reset again", 0, 0, 0);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    rst = 1'b0;
    wait_clk(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule